// File: doc/BRIEF.md
# Dual-Threshold Auto-Reset Fault Timer

This block supervises a half-bridge lamp converter. It replaces an analog timing capacitor with a single saturating accumulator. It receives digitised comparator flags: an overload flag for the low current threshold, a short-circuit flag for the high threshold, a below-low flag used to decide that a fault has cleared, an external latch request and an over-temperature flag. From these it drives a bridge enable, a request that pins the oscillator at its minimum frequency, a flag that shows the accumulator is charging toward a trip, and a latched-fault status.

When an overload first appears, the accumulator is preset to 5/12 of its trip level. It then charges in steps, one step per line-half-cycle strobe during which a fault flag was seen. A short circuit adds a much larger step on top of the overload step. On reaching the trip level the bridge turns off and the accumulator bleeds down to the restart level (2.4/12 of trip), after which the converter runs again. If the fault clears before the trip level is reached, the accumulator bleeds down the same way but the bridge stays on.

Two paths do not reset automatically: a sustained external latch request and an over-temperature flag. Either one shuts the bridge off until reset.

Top module: `fault_timer`

## Requirements
- R1: After reset, bridge_en is 1 and force_fmin, timing_act and latched are 0.
- R2: In normal operation, any clock with ol_flag or sc_flag high starts fault timing on the next clock. From then on, timing_act and force_fmin are 1 and the accumulator starts at 5*UNIT, which is 5/12 of the trip level 12*UNIT.
- R3: In timing, each half_cyc strobe that ends a half cycle in which ol_flag was seen (and sc_flag was not) adds OL_STEP. With the default values, the 70th such strobe after detection trips the block.
- R4: When sc_flag was seen in the half cycle, the strobe adds OL_STEP+SC_STEP, ten times the overload rate by default. With the default values, the 7th such strobe trips the block.
- R5: At the trip, bridge_en goes to 0, force_fmin stays 1 and timing_act goes to 0. Each later strobe removes BLEED_STEP while every fault flag is ignored. The strobe that finds the accumulator within BLEED_STEP of the restart level 12*UNIT/5 restores normal operation with bridge_en 1. With the default values this is the 96th strobe.
- R6: In timing, a strobe that ends a half cycle with no fault flag seen and with below_low high on every clock moves the block to recovery. In recovery, bridge_en stays 1, force_fmin is 1 and timing_act is 0. The block bleeds by BLEED_STEP per strobe and returns to normal by the same restart rule as R5.
- R7: In timing, a strobe that ends a half cycle with no fault flag seen and with below_low not high throughout leaves the accumulator and the state unchanged.
- R8: After an auto-restart, a fault that is still present starts timing again from the 5*UNIT preset.
- R9: ext_latch held high for LATCH_CYC consecutive clocks sets latched. A shorter pulse has no effect.
- R10: over_temp high on a clock sets latched on the next clock. While latched, bridge_en, force_fmin and timing_act are 0, and only reset clears the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (supply cycle) |
| half_cyc | input | 1 | One-clock strobe at each line half-cycle peak |
| ol_flag | input | 1 | Current above the low (overload) threshold |
| sc_flag | input | 1 | Current above the high (short-circuit) threshold |
| below_low | input | 1 | Current below the fault-clear level |
| ext_latch | input | 1 | External latched-shutdown request |
| over_temp | input | 1 | Die over-temperature flag |
| bridge_en | output | 1 | Half-bridge drive allowed |
| force_fmin | output | 1 | Hold oscillator at minimum frequency |
| timing_act | output | 1 | Accumulator charging toward a trip |
| latched | output | 1 | Latched fault; cleared only by reset |

## Verification
The hardest case to reach is the hysteresis band of R7. In that case a half cycle carries neither a fault flag nor a full-width below-low, and it must neither charge nor clear. Its only effect at the ports is that the trip comes later. The stimulus therefore places three band half-cycles inside an overload run and then checks that the block trips on exactly the 70th charging strobe, not earlier. The bleed counts of R5 and R6 are likewise checked at their exact strobe, so any error in the preset, step or restart level shifts the edge seen on bridge_en or force_fmin.

// File: rtl/fault_timer.sv
module fault_timer #(
  parameter int UNIT       = 100,
  parameter int OL_STEP    = 10,
  parameter int SC_STEP    = 90,
  parameter int BLEED_STEP = 10,
  parameter int LATCH_CYC  = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_cyc,
  input  logic ol_flag,
  input  logic sc_flag,
  input  logic below_low,
  input  logic ext_latch,
  input  logic over_temp,
  output logic bridge_en,
  output logic force_fmin,
  output logic timing_act,
  output logic latched
);

  localparam int TRIP_LVL    = 12 * UNIT;
  localparam int PRESET_LVL  = 5 * UNIT;
  localparam int RESTART_LVL = (12 * UNIT) / 5;
  localparam int AW = $clog2(TRIP_LVL + OL_STEP + SC_STEP + 1);
  localparam int LW = $clog2(LATCH_CYC + 1);

  typedef enum logic [2:0] {S_RUN, S_TIME, S_SHUT, S_RECOV, S_LATCH} st_t;

  st_t st, st_n;
  logic [AW-1:0] acc, acc_n;
  logic ol_seen, sc_seen, bl_all;
  logic [LW-1:0] lat_cnt;

  wire fault_now = ol_flag | sc_flag;
  wire ol_hit    = ol_seen | fault_now;
  wire sc_hit    = sc_seen | sc_flag;
  wire bl_ok     = bl_all & below_low;
  wire lat_go    = over_temp | (ext_latch && lat_cnt == LW'(LATCH_CYC - 1));

  wire [AW-1:0] step   = sc_hit ? AW'(OL_STEP + SC_STEP) : AW'(OL_STEP);
  wire [AW:0]   sum    = {1'b0, acc} + {1'b0, step};
  wire          at_flr = acc <= AW'(RESTART_LVL + BLEED_STEP);

  always_comb begin
    st_n  = st;
    acc_n = acc;
    if (lat_go) begin
      st_n  = S_LATCH;
      acc_n = '0;
    end else begin
      case (st)
        S_RUN:
          if (fault_now) begin
            st_n  = S_TIME;
            acc_n = AW'(PRESET_LVL);
          end
        S_TIME:
          if (half_cyc) begin
            if (ol_hit) begin
              if (sum >= (AW+1)'(TRIP_LVL)) begin
                st_n  = S_SHUT;
                acc_n = AW'(TRIP_LVL);
              end else begin
                acc_n = sum[AW-1:0];
              end
            end else if (bl_ok) begin
              st_n = S_RECOV;
            end
          end
        S_SHUT, S_RECOV:
          if (st == S_RECOV && fault_now) begin
            st_n = S_TIME;
          end else if (half_cyc) begin
            if (at_flr) begin
              st_n  = S_RUN;
              acc_n = '0;
            end else begin
              acc_n = acc - AW'(BLEED_STEP);
            end
          end
        default: st_n = S_LATCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_RUN;
      acc     <= '0;
      ol_seen <= 1'b0;
      sc_seen <= 1'b0;
      bl_all  <= 1'b1;
      lat_cnt <= '0;
    end else begin
      st  <= st_n;
      acc <= acc_n;
      if (half_cyc) begin
        ol_seen <= 1'b0;
        sc_seen <= 1'b0;
        bl_all  <= 1'b1;
      end else begin
        ol_seen <= ol_hit;
        sc_seen <= sc_hit;
        bl_all  <= bl_ok;
      end
      if (!ext_latch)                        lat_cnt <= '0;
      else if (lat_cnt != LW'(LATCH_CYC - 1)) lat_cnt <= lat_cnt + 1'b1;
    end
  end

  assign bridge_en  = (st == S_RUN) || (st == S_TIME) || (st == S_RECOV);
  assign force_fmin = (st == S_TIME) || (st == S_SHUT) || (st == S_RECOV);
  assign timing_act = (st == S_TIME);
  assign latched    = (st == S_LATCH);

  a_r2_preset_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_RUN && st == S_TIME) |-> acc == AW'(PRESET_LVL));

  a_r2_timing_forces_fmin: assert property (@(posedge clk) disable iff (!rst_n)
    timing_act |-> force_fmin);

  a_r3_acc_capped: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= AW'(TRIP_LVL));

  a_r5_trip_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bridge_en) && !latched) |-> acc == AW'(TRIP_LVL));

  a_r5_bleed_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHUT || st == S_RECOV) |-> acc >= AW'(RESTART_LVL));

  a_r7_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(half_cyc) && st == $past(st) && (st == S_TIME || st == S_SHUT))
      |-> acc == $past(acc));

  a_r9_latch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(latched) && !$past(over_temp)) |-> $past(ext_latch));

  a_r10_overtemp_latches: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp |=> latched);

  a_r10_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> latched);

  a_r10_latch_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    latched |-> (!bridge_en && !force_fmin && !timing_act));

endmodule

// File: tb/fault_timer_test.sv
module fault_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_cyc = 1'b0, ol_flag = 1'b0, sc_flag = 1'b0, below_low = 1'b1;
  logic ext_latch = 1'b0, over_temp = 1'b0;
  logic bridge_en, force_fmin, timing_act, latched;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  fault_timer uut (
    .clk(clk), .rst_n(rst_n), .half_cyc(half_cyc), .ol_flag(ol_flag),
    .sc_flag(sc_flag), .below_low(below_low), .ext_latch(ext_latch),
    .over_temp(over_temp), .bridge_en(bridge_en), .force_fmin(force_fmin),
    .timing_act(timing_act), .latched(latched)
  );

  // row: {reps[7:0], ol, sc, bl, exp_bridge, exp_fmin, exp_timing, req[3:0]}
  localparam int NROW = 20;
  localparam logic [17:0] TBL [NROW] = '{
    {8'd2,  3'b001, 3'b100, 4'd1},  // R1 idle
    {8'd1,  3'b100, 3'b111, 4'd2},  // R2 detect, 510
    {8'd68, 3'b100, 3'b111, 4'd3},  // R3 to 1190
    {8'd1,  3'b100, 3'b010, 4'd3},  // R3 70th strobe trips
    {8'd95, 3'b110, 3'b010, 4'd5},  // R5 bleed, flags ignored
    {8'd1,  3'b100, 3'b100, 4'd5},  // R5 96th strobe restarts
    {8'd1,  3'b100, 3'b111, 4'd8},  // R8 re-preset, 510
    {8'd1,  3'b001, 3'b110, 4'd6},  // R6 clear -> recovery
    {8'd26, 3'b001, 3'b110, 4'd6},  // R6 bleed
    {8'd1,  3'b001, 3'b100, 4'd6},  // R6 back to normal, bridge never off
    {8'd1,  3'b110, 3'b111, 4'd4},  // R4 preset+100 = 600
    {8'd5,  3'b110, 3'b111, 4'd4},  // R4 to 1100
    {8'd1,  3'b110, 3'b010, 4'd4},  // R4 7th strobe trips
    {8'd95, 3'b001, 3'b010, 4'd5},  // R5 bleed
    {8'd1,  3'b001, 3'b100, 4'd5},  // R5 restart
    {8'd1,  3'b100, 3'b111, 4'd2},  // R2 510
    {8'd3,  3'b000, 3'b111, 4'd7},  // R7 band: hold
    {8'd68, 3'b100, 3'b111, 4'd7},  // R7 1190, no early trip
    {8'd1,  3'b100, 3'b010, 4'd7},  // R7 trips exactly here
    {8'd96, 3'b001, 3'b010, 4'd5}   // R5 last strobe checked below
  };

  task automatic chk(input int req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic outs(input int req, input logic b, input logic f, input logic t, input logic l);
    chk(req, "bridge_en", bridge_en, b);
    chk(req, "force_fmin", force_fmin, f);
    chk(req, "timing_act", timing_act, t);
    chk(req, "latched", latched, l);
  endtask

  task automatic half(input logic o, input logic s, input logic b);
    ol_flag = o; sc_flag = s; below_low = b;
    repeat (3) @(negedge clk);
    half_cyc = 1'b1;
    @(negedge clk);
    half_cyc = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ol_flag = 0; sc_flag = 0; below_low = 1; ext_latch = 0; over_temp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  logic [17:0] row;

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    outs(1, 1, 0, 0, 0);  // R1 reset state

    for (int i = 0; i < NROW; i++) begin
      row = TBL[i];
      for (int k = 0; k < int'(row[17:10]); k++) begin
        half(row[9], row[8], row[7]);
        if (i == NROW - 1 && k == int'(row[17:10]) - 1)
          outs(5, 1, 0, 0, 0);  // R5 restart after 96 bleed strobes
        else
          outs(int'(row[3:0]), row[6], row[5], row[4], 1'b0);
      end
    end

    // R9: pulse one clock short has no effect
    do_reset();
    ext_latch = 1'b1;
    repeat (124) @(negedge clk);
    ext_latch = 1'b0;
    @(negedge clk);
    outs(9, 1, 0, 0, 0);
    // R9: full-length hold latches
    ext_latch = 1'b1;
    repeat (125) @(negedge clk);
    ext_latch = 1'b0;
    outs(9, 0, 0, 0, 1);
    half(1, 1, 0);
    outs(10, 0, 0, 0, 1);  // R10 latch survives faults and strobes

    // R10: over-temperature during timing
    do_reset();
    half(1, 0, 0);
    outs(2, 1, 1, 1, 0);
    over_temp = 1'b1;
    @(negedge clk);
    over_temp = 1'b0;
    outs(10, 0, 0, 0, 1);
    half(0, 0, 1);
    half(1, 0, 0);
    outs(10, 0, 0, 0, 1);
    do_reset();
    outs(10, 1, 0, 0, 0);  // R10 only reset clears

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule